// File: doc/BRIEF.md
# Interleaved Two-Phase Switching Clock Generator

This block turns a fast system clock into the switching timebase for two converter channels. The switching period is split into eight equal slots of 45 degrees, and each slot lasts `SUB_PER_SLOT` system clocks. A master cycle is half a switching period. Each master cycle starts the turn-on of one channel, and the two channels take turns. Their turn-on instants are therefore half a period apart.

A chaining clock output runs at the master rate and rises one slot after every turn-on instant. This output can drive the sync input of a second copy, giving four-phase interleaving. Each channel has a duty request counted in slots. That request gates the channel's switch-enable output, and a one-cycle strobe marks the channel's turn-on.

When external sync is selected, each qualified sync pulse restarts the master cycle. Sync is passed through a synchronizer and must meet a minimum width. While the block is locked to external sync, channel 1 duty is capped at six slots. If no qualified pulse arrives within one and a half nominal master periods, the block returns to its internal timebase and raises a loss flag.

Top module: `ilv_phase_gen`

## Requirements
- R1: In internal mode, a turn-on strobe for channel 1 (`on1`) occurs every 8·`SUB_PER_SLOT` clocks (32 with default parameters). The first one appears on the first clock edge after reset is released. While reset is held, `on1`, `on2`, `cko` and `sync_lost` are low.
- R2: The channel 2 strobe `on2` comes exactly half a switching period (16 clocks by default) after `on1`. The two strobes never occur in the same cycle, and successive strobes alternate between the channels.
- R3: `cko` is high during slots 1, 2, 5 and 6 of the switching period. It therefore rises one slot (4 clocks by default) after each turn-on instant and has 50% duty at twice the channel frequency.
- R4: Each `swN` is high for the first D slots of its channel's period, where D is its duty request. Values above 8 act as 8. A channel with D = 0 produces no strobe and its switch-enable stays low.
- R5: While external sync is selected and locked, channel 1 duty is limited to 6 slots (75%). Channel 2 is never limited, and in internal mode channel 1 is not limited either.
- R6: A sync pulse is accepted only if it stays high, after the synchronizer, for at least `MIN_PW` consecutive clocks. Shorter pulses are ignored. The first accepted pulse locks the block.
- R7: `sync_lost` is high when `sync_sel` is set and no pulse has been accepted in the last 1.5 master periods (24 clocks by default). In that state the internal timebase runs on. With `sync_sel` low, the sync input is ignored and `sync_lost` is low.
- R8: Each accepted pulse starts a master cycle. If it lands in the first half of the running master cycle, it realigns that cycle without a new strobe. Otherwise it starts the other channel's turn-on at once. Under steady sync, turn-on strobes are therefore spaced by the sync period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_sel | input | 1 | Selects external sync |
| sync_in | input | 1 | External sync pulse train at the master rate |
| duty1 | input | 4 | Channel 1 duty request in slots |
| duty2 | input | 4 | Channel 2 duty request in slots |
| sw1 | output | 1 | Channel 1 gated switch enable |
| sw2 | output | 1 | Channel 2 gated switch enable |
| on1 | output | 1 | Channel 1 turn-on strobe |
| on2 | output | 1 | Channel 2 turn-on strobe |
| cko | output | 1 | Chaining clock, 45 degrees after each turn-on |
| sync_lost | output | 1 | External sync selected but not locked |

## Verification
The hardest case to reach from the ports is realignment against a sync period that differs from nominal. A pulse that lands just after an internal wrap must not create an extra turn-on, and one that lands late in a cycle must start the other channel. The bench drives a background sync generator with programmable period and width. It runs it at 14, 15, 17 and 18 clocks after lock and checks that strobes stay spaced by the sync period and keep alternating. Width filtering and timeout are reached by shrinking the pulse width below the minimum and by stopping the generator. The loss flag is checked on both sides of the timeout, measured from the last sync rise.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
   localparam int SLOTS      = 8;
   localparam int SLOT_W     = $clog2(SLOTS);
   localparam int HALF_SLOTS = SLOTS / 2;
   localparam int CAP_SLOTS  = 6;
   localparam int DUTY_W     = 4;

   // saturate a request to a full period, then apply the optional cap
   function automatic logic [DUTY_W-1:0] eff_duty(input logic [DUTY_W-1:0] req,
                                                  input logic cap);
      logic [DUTY_W-1:0] r;
      r = (req > DUTY_W'(SLOTS)) ? DUTY_W'(SLOTS) : req;
      if (cap && (r > DUTY_W'(CAP_SLOTS)))
         r = DUTY_W'(CAP_SLOTS);
      return r;
   endfunction
endpackage

// File: rtl/ipg_sync_qual.sv
module ipg_sync_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PW      = 3,
   parameter int TIMEOUT     = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_sel,
   input  logic sync_in,
   output logic acc,
   output logic locked
);
   localparam int GAP_W = $clog2(TIMEOUT + 1);

   logic [SYNC_STAGES-1:0] sh_q;
   logic                   s_last;
   logic                   acc_raw;
   logic [GAP_W-1:0]       gap_q;
   logic                   locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-2:0], sync_in};
   end
   assign s_last = sh_q[SYNC_STAGES-1];

   generate
      if (MIN_PW == 1) begin : g_edge
         logic s_prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_prev_q <= 1'b0;
            else        s_prev_q <= s_last;
         end
         assign acc_raw = s_last & ~s_prev_q;
      end else begin : g_width
         localparam int HI_W = $clog2(MIN_PW + 1);
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     hi_q <= '0;
            else if (!s_last)               hi_q <= '0;
            else if (hi_q != HI_W'(MIN_PW)) hi_q <= hi_q + 1'b1;
         end
         assign acc_raw = s_last && (hi_q == HI_W'(MIN_PW - 1));
      end
   endgenerate

   assign acc = acc_raw & sync_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q    <= '0;
         locked_q <= 1'b0;
      end else if (!sync_sel) begin
         gap_q    <= '0;
         locked_q <= 1'b0;
      end else if (acc) begin
         gap_q    <= '0;
         locked_q <= 1'b1;
      end else if (gap_q == GAP_W'(TIMEOUT - 1)) begin
         locked_q <= 1'b0;
      end else begin
         gap_q    <= gap_q + 1'b1;
      end
   end
   assign locked = locked_q;

   assert_gap_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q < GAP_W'(TIMEOUT));
   assert_lock_needs_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(acc));
endmodule

// File: rtl/ipg_phase_ctr.sv
module ipg_phase_ctr #(
   parameter int SUB_PER_SLOT = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       realign,
   output logic [ipg_pkg::SLOT_W-1:0] slot,
   output logic                       start,
   output logic                       cko
);
   localparam int MASTER = ipg_pkg::HALF_SLOTS * SUB_PER_SLOT;
   localparam int POS_W  = $clog2(MASTER);
   localparam int HALFM  = MASTER / 2;

   logic [POS_W-1:0] pos_q, pos_n;
   logic             ch_q, ch_n;
   logic             wrap;
   logic             start_q, cko_q;

   always_comb begin
      pos_n = pos_q + 1'b1;
      ch_n  = ch_q;
      wrap  = 1'b0;
      if (realign) begin
         pos_n = '0;
         if (pos_q >= POS_W'(HALFM)) begin
            ch_n = ~ch_q;
            wrap = 1'b1;
         end
      end else if (pos_q == POS_W'(MASTER - 1)) begin
         pos_n = '0;
         ch_n  = ~ch_q;
         wrap  = 1'b1;
      end
   end

   // reset one count before a wrap so channel 1 turns on at the first edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= POS_W'(MASTER - 1);
         ch_q    <= 1'b1;
         start_q <= 1'b0;
         cko_q   <= 1'b0;
      end else begin
         pos_q   <= pos_n;
         ch_q    <= ch_n;
         start_q <= wrap;
         cko_q   <= pos_n[POS_W-1] ^ pos_n[POS_W-2];
      end
   end

   assign slot  = {ch_q, pos_q[POS_W-1 -: 2]};
   assign start = start_q;
   assign cko   = cko_q;

   assert_start_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (pos_q == '0));
   assert_cko_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cko_q) |-> (pos_q == POS_W'(SUB_PER_SLOT)));
endmodule

// File: rtl/ipg_chan_gate.sv
module ipg_chan_gate #(
   parameter int CH_IDX = 0
) (
   input  logic [ipg_pkg::SLOT_W-1:0] slot,
   input  logic                       start,
   input  logic [ipg_pkg::DUTY_W-1:0] duty,
   input  logic                       ext_active,
   output logic                       sw,
   output logic                       on
);
   import ipg_pkg::*;
   localparam logic [SLOT_W-1:0] OFFS  = SLOT_W'(CH_IDX * HALF_SLOTS);
   localparam logic              CAPEN = (CH_IDX == 0);

   logic [SLOT_W-1:0] rel;
   logic [DUTY_W-1:0] eff;

   assign rel = slot - OFFS;
   assign eff = eff_duty(duty, CAPEN & ext_active);
   assign sw  = DUTY_W'(rel) < eff;
   assign on  = start && (rel == '0) && (eff != '0);
endmodule

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen #(
   parameter int SUB_PER_SLOT = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int MIN_PW       = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sync_sel,
   input  logic                       sync_in,
   input  logic [ipg_pkg::DUTY_W-1:0] duty1,
   input  logic [ipg_pkg::DUTY_W-1:0] duty2,
   output logic                       sw1,
   output logic                       sw2,
   output logic                       on1,
   output logic                       on2,
   output logic                       cko,
   output logic                       sync_lost
);
   import ipg_pkg::*;
   localparam int MASTER = HALF_SLOTS * SUB_PER_SLOT;
   localparam int TMO    = MASTER + MASTER / 2;

   generate
      if (SUB_PER_SLOT < 1 || (SUB_PER_SLOT & (SUB_PER_SLOT - 1)) != 0) begin : g_bad_sub
         $error("SUB_PER_SLOT must be a power of two");
      end
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_PW < 1 || MIN_PW >= MASTER) begin : g_bad_pw
         $error("MIN_PW must be 1 .. master period - 1");
      end
   endgenerate

   logic              acc, locked, ext_active;
   logic [SLOT_W-1:0] slot;
   logic              start;
   logic [1:0]        sw_v, on_v;
   logic [DUTY_W-1:0] duty_v [2];

   ipg_sync_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_PW(MIN_PW), .TIMEOUT(TMO)) u_sync (
      .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .sync_in(sync_in),
      .acc(acc), .locked(locked));

   ipg_phase_ctr #(.SUB_PER_SLOT(SUB_PER_SLOT)) u_phase (
      .clk(clk), .rst_n(rst_n), .realign(acc),
      .slot(slot), .start(start), .cko(cko));

   assign ext_active = sync_sel & locked;
   assign duty_v[0]  = duty1;
   assign duty_v[1]  = duty2;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_ch
         ipg_chan_gate #(.CH_IDX(g)) u_gate (
            .slot(slot), .start(start), .duty(duty_v[g]), .ext_active(ext_active),
            .sw(sw_v[g]), .on(on_v[g]));
      end
   endgenerate

   assign sw1       = sw_v[0];
   assign sw2       = sw_v[1];
   assign on1       = on_v[0];
   assign on2       = on_v[1];
   assign sync_lost = sync_sel & ~locked;

   assert_antiphase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(on1 && on2));
   assert_duty_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_active |-> !(sw1 && (slot >= SLOT_W'(CAP_SLOTS))));
endmodule

// File: tb/sim_ilv_phase_gen.sv
module sim_ilv_phase_gen;
   localparam int CLK_PER = 10;
   localparam int SUB     = 4;
   localparam int MPW     = 3;
   localparam int HALF    = 4 * SUB;
   localparam int PER     = 2 * HALF;

   logic       clk, rst_n, sync_sel, sync_in;
   logic [3:0] duty1, duty2;
   logic       sw1, sw2, on1, on2, cko, sync_lost;

   int  n_chk = 0, n_err = 0, cyc = 0, last_rise = 0;
   int  sync_per = 16, sync_w = MPW;
   bit  sync_on = 0;

   ilv_phase_gen #(.SUB_PER_SLOT(SUB), .SYNC_STAGES(2), .MIN_PW(MPW)) u0 (
      .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .sync_in(sync_in),
      .duty1(duty1), .duty2(duty2), .sw1(sw1), .sw2(sw2), .on1(on1), .on2(on2),
      .cko(cko), .sync_lost(sync_lost));

   initial begin
      clk = 0;
      forever #(CLK_PER/2) clk = ~clk;
   end

   always @(posedge clk) cyc <= cyc + 1;

   // background sync generator
   initial begin
      sync_in = 0;
      forever begin
         @(posedge clk); #1;
         if (sync_on) begin
            sync_in = 1;
            last_rise = cyc;
            repeat (sync_w) @(posedge clk);
            #1 sync_in = 0;
            repeat (sync_per - sync_w - 1) @(posedge clk);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_duty(input int d, input bit cap);
      int e;
      e = (d > 8) ? 8 : d;
      if (cap && e > 6) e = 6;
      return e;
   endfunction

   // one switching period from a channel 1 strobe
   task automatic run_period(input int d1, input int d2, input bit capped);
      int c1, c2, o2, ck, e1, e2;
      bit got, extra;
      duty1 = 4'(d1);
      duty2 = 4'(d2);
      nclk(80);
      got = 0;
      for (int i = 0; i < 100 && !got; i++) begin
         @(negedge clk);
         if (on1) got = 1;
      end
      chk(got, "R1 strobe seen", int'(got), 1);
      if (got) begin
         c1 = 0; c2 = 0; o2 = -1; ck = -1; extra = 0;
         for (int k = 0; k < PER; k++) begin
            if (k > 0) @(negedge clk);
            c1 += int'(sw1);
            c2 += int'(sw2);
            if (on2 && o2 < 0) o2 = k;
            if (cko && ck < 0) ck = k;
            if (k > 0 && on1) extra = 1;
         end
         @(negedge clk);
         chk(on1 && !extra, "R1 period", int'(on1), 1);
         e1 = exp_duty(d1, capped);
         e2 = exp_duty(d2, 1'b0);
         if (capped) chk(c1 == 4 * e1, "R5 ch1 on-time", c1, 4 * e1);
         else        chk(c1 == 4 * e1, "R4 ch1 on-time", c1, 4 * e1);
         chk(c2 == 4 * e2, "R4 ch2 on-time", c2, 4 * e2);
         chk(o2 == ((e2 > 0) ? HALF : -1), "R2 ch2 offset", o2, (e2 > 0) ? HALF : -1);
         chk(ck == SUB, "R3 cko offset", ck, SUB);
      end
   endtask

   // spacing and alternation of turn-on strobes
   task automatic run_iv(input int expect_iv, input string req);
      int t [6];
      bit w [6];
      int n;
      nclk(120);
      n = 0;
      for (int i = 0; i < 400 && n < 6; i++) begin
         @(negedge clk);
         if (on1 || on2) begin
            t[n] = cyc;
            w[n] = on2;
            n++;
         end
      end
      chk(n == 6, req, n, 6);
      for (int i = 1; i < n; i++) begin
         chk(t[i] - t[i-1] == expect_iv, req, t[i] - t[i-1], expect_iv);
         chk(w[i] != w[i-1], "R2 alternation", int'(w[i]), int'(!w[i-1]));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int unused_seed;
      int onseen, swseen;
      unused_seed = $urandom(32'd7411);
      rst_n = 0; sync_sel = 0; duty1 = 4'd3; duty2 = 4'd2;
      nclk(5);
      chk(!on1 && !on2, "R1 reset strobes", int'(on1 | on2), 0);
      chk(!cko, "R1 reset cko", int'(cko), 0);
      chk(!sync_lost, "R1 reset lost", int'(sync_lost), 0);
      rst_n = 1;
      @(negedge clk);
      chk(on1, "R1 first strobe", int'(on1), 1);

      // internal mode, random duties
      for (int i = 0; i < 8; i++)
         run_period(int'($urandom_range(1, 12)), int'($urandom_range(0, 12)), 1'b0);
      run_period(8, 8, 1'b0);
      run_period(15, 1, 1'b0);

      // zero duty on channel 1
      duty1 = 0; duty2 = 4'd3;
      nclk(40);
      onseen = 0; swseen = 0;
      for (int k = 0; k < 2 * PER; k++) begin
         @(negedge clk);
         onseen += int'(on1);
         swseen += int'(sw1);
      end
      chk(onseen == 0 && swseen == 0, "R4 zero duty", onseen + swseen, 0);

      // sync ignored when not selected
      duty1 = 4'd4;
      sync_per = 14; sync_w = MPW; sync_on = 1;
      run_iv(HALF, "R7 ignore sync");
      chk(!sync_lost, "R7 lost when unselected", int'(sync_lost), 0);

      // pulse width qualification
      sync_per = 16; sync_w = MPW - 1; sync_sel = 1;
      nclk(100);
      chk(sync_lost, "R6 narrow pulse rejected", int'(sync_lost), 1);
      sync_w = MPW;
      nclk(60);
      chk(!sync_lost, "R6 wide pulse locks", int'(sync_lost), 0);

      // locked at nominal rate: channel 1 cap
      run_period(8, 5, 1'b1);
      run_period(12, 8, 1'b1);
      for (int i = 0; i < 4; i++)
         run_period(int'($urandom_range(1, 12)), int'($urandom_range(0, 12)), 1'b1);

      // off-nominal sync periods
      duty1 = 4'd3; duty2 = 4'd3;
      sync_per = 14; run_iv(14, "R8 period 14");
      sync_per = 18; run_iv(18, "R8 period 18");
      for (int i = 0; i < 3; i++) begin
         sync_per = ($urandom_range(0, 1) == 0) ? 15 : 17;
         run_iv(sync_per, "R8 random period");
      end

      // timeout and fallback
      sync_per = 16;
      nclk(100);
      sync_on = 0;
      @(negedge clk);
      while (cyc < last_rise + 20) @(negedge clk);
      chk(!sync_lost, "R7 lock held", int'(sync_lost), 0);
      while (cyc < last_rise + 40) @(negedge clk);
      chk(sync_lost, "R7 timeout", int'(sync_lost), 1);
      run_iv(HALF, "R7 fallback rate");
      run_period(8, 3, 1'b0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule